// File: doc/BRIEF.md
# ADC Engine Control and Channel Scanner

This block is the digital control side of a multichannel analog-to-digital converter. It holds a 32-bit engine control word, tracks the operating mode and a start-up (init-ready) condition, and walks through the enabled channels one at a time. It takes one channel per sample tick, in ascending order, and wraps around. A request/result handshake stands in for the analog converter. The block raises a request with a channel number and holds it until the converter returns a 10-bit result with a done strobe. The result is then stored zero-extended in that channel's 16-bit data register.

Software reaches the control word and the result registers through a flat 32-bit read/write port with a byte address. The control word sits at offset 0x00. Result n is the 16-bit half-word at offset 0x10 + 2n, so one 32-bit read at 0x10 + 4k returns channel 2k in the low half and channel 2k+1 in the high half. The reference-select, compensation and channel-7 battery bits are only stored and driven out as pins for the analog side.

Top module: `adc_engine_ctrl`

## Requirements
- R1: After reset the control word reads 0, every result register reads 0, init-ready is 0 and `conv_req` is low.
- R2: The control word at offset 0x00 stores bit 0 (engine enable), bits [3:1] (mode: 0 power-down, 1 standby, 7 normal), bits [7:4], bits [13:12] and bits [31:16] (bit 16+n enables channel n). Bits 8..11, 14 and 15 ignore writes. Bit 8 reads back the init-ready flag and the other ignored bits read 0.
- R3: While engine enable is 1 and the mode is 7, init-ready (bit 8) sets after INIT_TICKS sample ticks, with INIT_TICKS = 4 by default. It clears one cycle after the mode field becomes 0, and the count then starts over.
- R4: No conversion is requested while init-ready is 0.
- R5: Each sample tick with the engine running, init-ready set, no conversion outstanding and a nonzero enable mask starts a conversion. It takes the next enabled channel above the last one converted, wrapping from 15 to 0 and skipping disabled channels. The first channel after reset is the lowest enabled one.
- R6: A done strobe while a request is outstanding stores `conv_data` into the requested channel's register. The register reads as {6'b0, data} at half-word offset 0x10 + 2n.
- R7: When engine enable is 0 or the mode is not 7, the request is dropped by the next cycle, no new conversion starts and all results keep their values.
- R8: `conv_req` and `conv_ch` hold steady until `conv_done`. Sample ticks that arrive meanwhile are ignored and do not advance the channel order.
- R9: `vref_sel` follows control bits [7:6], `comp_sense_en` bit 4, `auto_comp_en` bit 5, `ch7_batt_mode` bit 12 and `batt_sense_en` bit 13.
- R10: Writes to any offset other than 0x00 have no effect. Reads of any offset that is not the control word or a result word return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte address of the register port |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| sample_tick | input | 1 | One-cycle sample pulse |
| conv_req | output | 1 | Conversion request to the converter |
| conv_ch | output | 4 | Channel being converted |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | 10 | Converter result |
| vref_sel | output | 2 | Reference select |
| comp_sense_en | output | 1 | Compensation sensing enable |
| auto_comp_en | output | 1 | Auto-compensation enable |
| ch7_batt_mode | output | 1 | Channel 7 battery mode |
| batt_sense_en | output | 1 | Battery sensing enable |

## Verification
A wrong "last channel" register shows on the very next tick: `conv_ch` names the wrong channel, and the result is then filed at the wrong half-word. A fault in the init counter shows as bit 8 set one tick early or late, or as a request during start-up, which is visible within INIT_TICKS ticks. A fault in the mode gating shows as a request or a changed result while in standby, disabled or power-down. A fault in storage shows at the next read of the result words, so the bench reads all of them back after every mask sweep.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam logic [7:0]  CTRL_OFS   = 8'h00;
    localparam logic [7:0]  DATA_BASE  = 8'h10;
    localparam logic [31:0] CTRL_WMASK = 32'hFFFF_30FF;

    typedef enum logic [2:0] {
        MODE_OFF  = 3'd0,
        MODE_STBY = 3'd1,
        MODE_RUN  = 3'd7
    } op_mode_e;

    typedef struct packed {
        logic [15:0] ch_en;
        logic [1:0]  rsv_hi;
        logic        batt_sense;
        logic        batt_ch7;
        logic [2:0]  rsv_mid;
        logic        init_rdy;
        logic [1:0]  vref_sel;
        logic        auto_comp;
        logic        comp_sense;
        logic [2:0]  mode;
        logic        eng_en;
    } ctrl_word_t;

    function automatic logic [3:0] next_chan(input logic [15:0] mask,
                                             input logic [3:0]  last,
                                             input int          n_ch);
        logic [3:0] pick;
        logic       found;
        pick  = last;
        found = 1'b0;
        for (int i = 1; i <= 16; i++) begin
            int idx;
            idx = (int'(last) + i) % n_ch;
            if (!found && i <= n_ch && mask[idx]) begin
                pick  = 4'(idx);
                found = 1'b1;
            end
        end
        return pick;
    endfunction

endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_scan_pkg::*;
#(
    parameter int INIT_TICKS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        sample_tick,
    output ctrl_word_t  ctrl,
    output logic        run
);
    localparam int CNT_W = (INIT_TICKS > 1) ? $clog2(INIT_TICKS) : 1;

    logic [31:0]      word_q;
    logic             init_q;
    logic [CNT_W-1:0] cnt_q;
    ctrl_word_t       stored;

    assign stored = ctrl_word_t'(word_q);
    assign run    = stored.eng_en && (op_mode_e'(stored.mode) == MODE_RUN);

    always_comb begin
        ctrl          = stored;
        ctrl.init_rdy = init_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (wr_en) begin
            word_q <= wdata & CTRL_WMASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || op_mode_e'(stored.mode) == MODE_OFF) begin
            init_q <= 1'b0;
            cnt_q  <= '0;
        end else if (run && !init_q && sample_tick) begin
            if (cnt_q == CNT_W'(INIT_TICKS - 1)) begin
                init_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_INIT_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(init_q) |-> $past(run && sample_tick)); // R3
    AST_PD_CLEARS_INIT: assert property (@(posedge clk) disable iff (rst)
        (stored.mode == 3'd0) |=> !init_q); // R3
endmodule

// File: rtl/adc_chan_scanner.sv
module adc_chan_scanner
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        init_rdy,
    input  logic [15:0] mask,
    input  logic        sample_tick,
    input  logic        conv_done,
    output logic        conv_req,
    output logic [3:0]  conv_ch,
    output logic        cap_en
);
    logic       busy_q;
    logic [3:0] ch_q;

    assign conv_req = busy_q;
    assign conv_ch  = ch_q;
    assign cap_en   = busy_q && conv_done && run;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ch_q   <= 4'(NUM_CH - 1);
        end else if (!run) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            if (conv_done) busy_q <= 1'b0;
        end else if (sample_tick && init_rdy && (|mask)) begin
            busy_q <= 1'b1;
            ch_q   <= next_chan(mask, ch_q, NUM_CH);
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (run && conv_req && !conv_done) |=> (conv_req && $stable(conv_ch))); // R8
    AST_REQ_NEEDS_INIT: assert property (@(posedge clk) disable iff (rst)
        conv_req |-> init_rdy); // R4
    AST_STOP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |=> !conv_req); // R7
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NUM_CH   = 16,
    parameter int RES_BITS = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cap_en,
    input  logic [3:0]                 cap_ch,
    input  logic [RES_BITS-1:0]        cap_data,
    output logic [NUM_CH-1:0][15:0]    data_q
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[g] <= '0;
            end else if (cap_en && cap_ch == 4'(g)) begin
                data_q[g] <= 16'(cap_data);
            end
        end
    end
endmodule

// File: rtl/adc_engine_ctrl.sv
module adc_engine_ctrl
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH     = 16,
    parameter int RES_BITS   = 10,
    parameter int INIT_TICKS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          reg_addr,
    input  logic                reg_wen,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                sample_tick,
    output logic                conv_req,
    output logic [3:0]          conv_ch,
    input  logic                conv_done,
    input  logic [RES_BITS-1:0] conv_data,
    output logic [1:0]          vref_sel,
    output logic                comp_sense_en,
    output logic                auto_comp_en,
    output logic                ch7_batt_mode,
    output logic                batt_sense_en
);
    localparam int CH_W = $clog2(NUM_CH);

    ctrl_word_t              ctrl;
    logic                    run;
    logic                    cap_en;
    logic [NUM_CH-1:0][15:0] data_q;
    logic [7:0]              ofs;
    logic [CH_W-1:0]         lo_idx;
    logic [CH_W-1:0]         hi_idx;

    adc_ctrl_regs #(.INIT_TICKS(INIT_TICKS)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_wen && reg_addr == CTRL_OFS),
        .wdata(reg_wdata), .sample_tick(sample_tick),
        .ctrl(ctrl), .run(run)
    );

    adc_chan_scanner #(.NUM_CH(NUM_CH)) u_scan (
        .clk(clk), .rst(rst), .run(run), .init_rdy(ctrl.init_rdy),
        .mask(ctrl.ch_en), .sample_tick(sample_tick), .conv_done(conv_done),
        .conv_req(conv_req), .conv_ch(conv_ch), .cap_en(cap_en)
    );

    adc_result_bank #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_bank (
        .clk(clk), .rst(rst), .cap_en(cap_en), .cap_ch(conv_ch),
        .cap_data(conv_data), .data_q(data_q)
    );

    assign vref_sel      = ctrl.vref_sel;
    assign comp_sense_en = ctrl.comp_sense;
    assign auto_comp_en  = ctrl.auto_comp;
    assign ch7_batt_mode = ctrl.batt_ch7;
    assign batt_sense_en = ctrl.batt_sense;

    assign ofs    = reg_addr - DATA_BASE;
    assign lo_idx = ofs[CH_W:1];
    assign hi_idx = lo_idx | CH_W'(1);

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_OFS) begin
            reg_rdata = ctrl;
        end else if (reg_addr >= DATA_BASE && ofs < 8'(2 * NUM_CH)
                     && ofs[1:0] == 2'b00) begin
            reg_rdata = {data_q[hi_idx], data_q[lo_idx]};
        end
    end
endmodule

// File: tb/tb_adc_engine_ctrl.sv
module tb_adc_engine_ctrl;
    localparam int INIT_T = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sample_tick = 1'b0;
    logic        conv_req;
    logic [3:0]  conv_ch;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_data = '0;
    logic [1:0]  vref_sel;
    logic        comp_sense_en, auto_comp_en, ch7_batt_mode, batt_sense_en;

    int checks = 0;
    int errors = 0;
    int last_ch = 15;
    int step = 0;
    logic [15:0] model [16];

    always #10 clk = ~clk;

    adc_engine_ctrl dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sample_tick(sample_tick),
        .conv_req(conv_req), .conv_ch(conv_ch), .conv_done(conv_done),
        .conv_data(conv_data), .vref_sel(vref_sel), .comp_sense_en(comp_sense_en),
        .auto_comp_en(auto_comp_en), .ch7_batt_mode(ch7_batt_mode),
        .batt_sense_en(batt_sense_en)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0; reg_addr = '0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string req);
        logic [31:0] v;
        reg_read(a, v);
        check(v === e, req, v, e);
    endtask

    function automatic int pick_next(input logic [15:0] m, input int last);
        for (int i = 1; i <= 16; i++) begin
            if (m[(last + i) % 16]) return (last + i) % 16;
        end
        return -1;
    endfunction

    task automatic check_all_data(input string req);
        for (int k = 0; k < 8; k++) begin
            expect_reg(8'(16 + 4 * k), {model[2*k+1], model[2*k]}, req);
        end
    endtask

    // One tick; converter answers immediately when a request is expected.
    task automatic do_tick(input logic [15:0] m, input bit active, input string req);
        int exp_ch;
        exp_ch = active ? pick_next(m, last_ch) : -1;
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        check(conv_req === (exp_ch >= 0), req, 32'(conv_req), 32'(exp_ch >= 0));
        if (exp_ch >= 0) begin
            check(conv_ch === 4'(exp_ch), req, 32'(conv_ch), 32'(exp_ch));
            conv_data = 10'((exp_ch * 41 + step * 7 + 3) & 32'h3FF);
            conv_done = 1'b1;
            model[exp_ch] = 16'(conv_data);
            last_ch = exp_ch;
            step++;
            @(negedge clk);
            conv_done = 1'b0;
            check(conv_req === 1'b0, req, 32'(conv_req), 32'd0);
        end
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] masks [6];
        logic [31:0] v;
        masks = '{16'hFFFF, 16'h8001, 16'h0124, 16'h0000, 16'hA5A5, 16'h0080};
        for (int i = 0; i < 16; i++) model[i] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        expect_reg(8'h00, 32'h0, "R1");
        check_all_data("R1");
        check(conv_req === 1'b0, "R1", 32'(conv_req), 32'd0);

        // R2 / R9 stored fields and routing
        reg_write(8'h00, 32'hFFFF_FFF0);
        expect_reg(8'h00, 32'hFFFF_30F0, "R2");
        check({vref_sel, comp_sense_en, auto_comp_en, ch7_batt_mode, batt_sense_en} === 6'b111111,
              "R9", 32'({vref_sel, comp_sense_en, auto_comp_en, ch7_batt_mode, batt_sense_en}), 32'h3F);
        reg_write(8'h00, 32'h0000_1040);
        expect_reg(8'h00, 32'h0000_1040, "R2");
        check({vref_sel, comp_sense_en, auto_comp_en, ch7_batt_mode, batt_sense_en} === 6'b010010,
              "R9", 32'({vref_sel, comp_sense_en, auto_comp_en, ch7_batt_mode, batt_sense_en}), 32'h12);

        // R3 / R4 start-up
        reg_write(8'h00, 32'hFFFF_000F);
        for (int t = 0; t < INIT_T; t++) begin
            expect_reg(8'h00, 32'hFFFF_000F, "R3");
            do_tick(16'hFFFF, 1'b0, "R4");
        end
        expect_reg(8'h00, 32'hFFFF_010F, "R3");

        // R5 / R6 mask sweep
        foreach (masks[mi]) begin
            reg_write(8'h00, {masks[mi], 16'h000F});
            for (int s = 0; s < 20; s++) do_tick(masks[mi], 1'b1, "R5");
            check_all_data("R6");
        end

        // R8 tick while busy
        reg_write(8'h00, 32'h0F0F_000F);
        @(negedge clk); sample_tick = 1'b1;
        @(negedge clk); sample_tick = 1'b0;
        v = 32'(pick_next(16'h0F0F, last_ch));
        check(conv_req === 1'b1 && conv_ch === v[3:0], "R8", 32'(conv_ch), v);
        @(negedge clk); sample_tick = 1'b1;
        @(negedge clk); sample_tick = 1'b0;
        @(negedge clk);
        check(conv_req === 1'b1 && conv_ch === v[3:0], "R8", 32'(conv_ch), v);
        conv_data = 10'h2AA; conv_done = 1'b1;
        model[v] = 16'h02AA; last_ch = int'(v);
        @(negedge clk); conv_done = 1'b0;
        check(conv_req === 1'b0, "R8", 32'(conv_req), 32'd0);
        do_tick(16'h0F0F, 1'b1, "R8");
        check_all_data("R8");

        // R7 standby, disabled, power-down
        reg_write(8'h00, 32'hFFFF_0003);
        do_tick(16'hFFFF, 1'b0, "R7");
        expect_reg(8'h00, 32'hFFFF_0103, "R7");
        reg_write(8'h00, 32'hFFFF_000E);
        do_tick(16'hFFFF, 1'b0, "R7");
        check_all_data("R7");
        reg_write(8'h00, 32'hFFFF_0001);
        @(negedge clk);
        expect_reg(8'h00, 32'hFFFF_0001, "R3");
        reg_write(8'h00, 32'hFFFF_000F);
        for (int t = 0; t < INIT_T; t++) do_tick(16'hFFFF, 1'b0, "R3");
        expect_reg(8'h00, 32'hFFFF_010F, "R3");
        do_tick(16'hFFFF, 1'b1, "R5");

        // R10 ignored writes, unmapped reads
        reg_write(8'h10, 32'hDEAD_BEEF);
        reg_write(8'h0C, 32'h1234_5678);
        reg_write(8'hC4, 32'h0000_000F);
        check_all_data("R10");
        expect_reg(8'h00, 32'hFFFF_010F, "R10");
        expect_reg(8'h0C, 32'h0, "R10");
        expect_reg(8'hC4, 32'h0, "R10");
        expect_reg(8'hD0, 32'h0, "R10");
        expect_reg(8'h12, 32'h0, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule